// File: doc/BRIEF.md
# Memory-Card Status and Interrupt Register

This block is a small board-control register set on a word-addressed bus. It returns a fixed identification word and a fixed decode word. It also has one live status register that reports two memory-card signals. The first is the current write-protect level, which the register simply mirrors. The second is a card-insert event, which the register latches and holds until software acknowledges it.

The latched card-insert event drives a single interrupt output. That output stays high until software writes a one to the event bit. The flash-programming word and the decode word accept writes and ignore them.

The sticky event is held by a two-state machine:

- `CD_IDLE`: no event is pending and the interrupt is low.
- `CD_PENDING`: an event is latched and the interrupt is high.

It has three transitions:

- *arm*: `CD_IDLE` to `CD_PENDING`, taken whenever the card-insert input is high at a clock edge.
- *acknowledge*: `CD_PENDING` to `CD_IDLE`, taken on a clearing write while the card-insert input is low.
- *hold*: the machine keeps its state in every other case, including a clearing write that lands while card-insert is still high.

Reads have no side effects. The read data is combinational from the index and the current state.

Top module: `cdi_card_status`

## Requirements
- R1: Index 0 reads 0x41034003, index 1 reads 0x00000000 and index 3 reads 0x00000011.
- R2: At index 2, bit 0 of the read data equals the write-protect input in the same cycle, following it both up and down. Bits other than 0 and 3 read 0.
- R3: Bit 3 of index 2 becomes 1 at the first clock edge at which the card-insert input is high. It stays 1 after that input returns low.
- R4: A write to index 2 with data bit 3 = 1 clears bit 3 at that clock edge when card-insert is low. A write to index 2 with data bit 3 = 0 leaves bit 3 unchanged, whatever the other data bits are.
- R5: The interrupt output always equals bit 3 of index 2. It rises at the setting edge and falls at the clearing edge.
- R6: Writes to indices 0, 1 and 3, with any data, change neither the interrupt output nor any read value.
- R7: When card-insert is high in the same cycle as a clearing write, bit 3 is 1 after the edge.
- R8: While reset (rst_n = 0, asynchronous) is asserted and after it is released, bit 3 and the interrupt output are 0.
- R9: Indices 4 and above read 0. Writes to them have no effect on the interrupt output or on bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_idx | input | IDX_W | Word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_idx (combinational) |
| wprot_lvl | input | 1 | Card write-protect level |
| card_in | input | 1 | Card-insert pulse or level |
| card_irq | output | 1 | Latched card-insert interrupt |

## Verification
The main function is tried in two ways.

The first is random traffic: the write-protect level toggles freely, card-insert pulses are sparse, and the index, write enable and data are random. This separates the live mirror from the sticky latch, because a pulse that has gone must still show on bit 3 while bit 0 tracks its input.

Directed cases then cover the remaining distinctions:
- A clear with data bit 3 = 0 against one with bit 3 = 1, which separates a write-one-clear from a plain write.
- A clear that meets a still-high card-insert, which exposes the priority of set over clear.
- Writes to the constant, ignored and unmapped indices, each followed by a read of index 2 that shows the event bit untouched.

// File: rtl/cdi_pkg.sv
package cdi_pkg;

    typedef enum logic {
        CD_IDLE    = 1'b0,
        CD_PENDING = 1'b1
    } cd_state_e;

    localparam int unsigned IDX_IDENT  = 0;
    localparam int unsigned IDX_FLASH  = 1;
    localparam int unsigned IDX_STATUS = 2;
    localparam int unsigned IDX_DECODE = 3;

endpackage

// File: rtl/cdi_write_decode.sv
module cdi_write_decode #(
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CI_BIT = 3
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              clear_req
);
    localparam logic [IDX_W-1:0] STATUS_IDX = IDX_W'(cdi_pkg::IDX_STATUS);

    // Only a write to the status word with a one in the event position acknowledges.
    always_comb begin
        clear_req = bus_sel && bus_we && (bus_idx == STATUS_IDX) && bus_wdata[CI_BIT];
    end
endmodule

// File: rtl/cdi_insert_fsm.sv
module cdi_insert_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic insert_i,
    input  logic clear_i,
    output logic pending_o
);
    import cdi_pkg::*;

    cd_state_e state_q;
    cd_state_e state_d;

    // Next-state: arm has priority over acknowledge.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CD_IDLE: begin
                if (insert_i) state_d = CD_PENDING;
            end
            CD_PENDING: begin
                if (clear_i && !insert_i) state_d = CD_IDLE;
            end
            default: state_d = CD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            CD_IDLE:    pending_o = 1'b0;
            CD_PENDING: pending_o = 1'b1;
            default:    pending_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cdi_read_mux.sv
module cdi_read_mux #(
    parameter int unsigned   IDX_W       = 4,
    parameter int unsigned   DATA_W      = 32,
    parameter logic [31:0]   ID_WORD     = 32'h4103_4003,
    parameter logic [31:0]   DECODE_WORD = 32'h0000_0011,
    parameter int unsigned   WP_BIT      = 0,
    parameter int unsigned   CI_BIT      = 3
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              wprot,
    input  logic              pending,
    output logic [DATA_W-1:0] rdata
);
    import cdi_pkg::*;

    logic [DATA_W-1:0] status_word;

    always_comb begin
        status_word         = '0;
        status_word[WP_BIT] = wprot;
        status_word[CI_BIT] = pending;
    end

    always_comb begin
        if (idx == IDX_W'(IDX_IDENT))       rdata = DATA_W'(ID_WORD);
        else if (idx == IDX_W'(IDX_STATUS)) rdata = status_word;
        else if (idx == IDX_W'(IDX_DECODE)) rdata = DATA_W'(DECODE_WORD);
        else                                rdata = '0;
    end
endmodule

// File: rtl/cdi_card_status.sv
module cdi_card_status #(
    parameter int unsigned IDX_W       = 4,
    parameter int unsigned DATA_W      = 32,
    parameter logic [31:0] ID_WORD     = 32'h4103_4003,
    parameter logic [31:0] DECODE_WORD = 32'h0000_0011,
    parameter int unsigned WP_BIT      = 0,
    parameter int unsigned CI_BIT      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wprot_lvl,
    input  logic              card_in,
    output logic              card_irq
);
    logic clear_req;
    logic pending;

    cdi_write_decode #(
        .IDX_W (IDX_W),
        .DATA_W(DATA_W),
        .CI_BIT(CI_BIT)
    ) u_wdec (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_idx  (bus_idx),
        .bus_wdata(bus_wdata),
        .clear_req(clear_req)
    );

    cdi_insert_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .insert_i (card_in),
        .clear_i  (clear_req),
        .pending_o(pending)
    );

    cdi_read_mux #(
        .IDX_W      (IDX_W),
        .DATA_W     (DATA_W),
        .ID_WORD    (ID_WORD),
        .DECODE_WORD(DECODE_WORD),
        .WP_BIT     (WP_BIT),
        .CI_BIT     (CI_BIT)
    ) u_rmux (
        .idx    (bus_idx),
        .wprot  (wprot_lvl),
        .pending(pending),
        .rdata  (bus_rdata)
    );

    assign card_irq = pending;
endmodule

// File: rtl/cdi_card_status_chk.sv
module cdi_card_status_chk #(
    parameter int unsigned IDX_W       = 4,
    parameter int unsigned DATA_W      = 32,
    parameter logic [31:0] ID_WORD     = 32'h4103_4003,
    parameter logic [31:0] DECODE_WORD = 32'h0000_0011,
    parameter int unsigned WP_BIT      = 0,
    parameter int unsigned CI_BIT      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [IDX_W-1:0]  bus_idx,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              wprot_lvl,
    input logic              card_in,
    input logic              card_irq
);
    logic clr_wr;
    assign clr_wr = bus_sel && bus_we && (bus_idx == IDX_W'(2)) && bus_wdata[CI_BIT];

    assert_ident_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idx == IDX_W'(0)) |-> (bus_rdata == DATA_W'(ID_WORD)));

    assert_wprot_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idx == IDX_W'(2)) |-> (bus_rdata[WP_BIT] == wprot_lvl));

    assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        card_in |=> card_irq);

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !card_in) |=> !card_irq);

    assert_irq_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idx == IDX_W'(2)) |-> (bus_rdata[CI_BIT] == card_irq));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (card_irq && !clr_wr) |=> card_irq);

    assert_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_irq) |-> $past(card_in));

    assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idx > IDX_W'(3)) |-> (bus_rdata == '0));

    // R8: reset holds the interrupt low.
    always @(posedge clk) begin
        if (!rst_n) assert_reset_R8: assert (card_irq == 1'b0);
    end
endmodule

bind cdi_card_status cdi_card_status_chk #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .ID_WORD(ID_WORD),
    .DECODE_WORD(DECODE_WORD), .WP_BIT(WP_BIT), .CI_BIT(CI_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wprot_lvl(wprot_lvl), .card_in(card_in), .card_irq(card_irq)
);

// File: tb/cdi_card_status_bench.sv
module cdi_card_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_idx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wprot_lvl = 1'b0;
    logic        card_in = 1'b0;
    logic        card_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit model_pend = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cdi_card_status u_cdi_card_status (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wprot_lvl(wprot_lvl), .card_in(card_in), .card_irq(card_irq)
    );

    function automatic logic [31:0] exp_rdata(logic [3:0] idx, bit wp, bit pend);
        case (idx)
            4'd0:    return 32'h4103_4003;
            4'd1:    return 32'h0;
            4'd2:    return {28'h0, pend, 2'b00, wp};
            4'd3:    return 32'h0000_0011;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string idx_tag(logic [3:0] idx);
        if (idx == 4'd2) return "R2";
        if (idx <= 4'd3) return "R1";
        return "R9";
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, compare before the edge, advance the model at the edge.
    task automatic step(bit wp, bit ci, bit sel, bit we, logic [3:0] idx, logic [31:0] wd);
        bit clr;
        @(negedge clk);
        wprot_lvl = wp; card_in = ci; bus_sel = sel; bus_we = we;
        bus_idx = idx; bus_wdata = wd;
        #2;
        check(idx_tag(idx), bus_rdata, exp_rdata(idx, wp, model_pend));
        check("R5", {31'h0, card_irq}, {31'h0, model_pend});
        clr = sel && we && (idx == 4'd2) && wd[3];
        @(posedge clk);
        if (ci) model_pend = 1'b1;
        else if (clr) model_pend = 1'b0;
    endtask

    task automatic peek_bit3(string tag, bit exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_idx = 4'd2; card_in = 1'b0;
        #2;
        check(tag, {31'h0, bus_rdata[3]}, {31'h0, exp});
        check(tag, {31'h0, card_irq}, {31'h0, exp});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0_FFEE));
        // R8: during reset
        #3;
        check("R8", {31'h0, card_irq}, 32'h0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R8", {31'h0, card_irq}, 32'h0);

        // R1 constants and R2 mirror both ways
        step(0, 0, 1, 0, 4'd0, 0);
        step(0, 0, 1, 0, 4'd1, 0);
        step(0, 0, 1, 0, 4'd3, 0);
        step(1, 0, 1, 0, 4'd2, 0);
        step(0, 0, 1, 0, 4'd2, 0);

        // R3: a one-cycle pulse latches and sticks
        step(0, 1, 0, 0, 4'd2, 0);
        peek_bit3("R3", 1'b1);
        step(0, 0, 1, 0, 4'd2, 0);

        // R4: write with bit 3 clear does nothing, other data bits ignored
        step(0, 0, 1, 1, 4'd2, 32'hFFFF_FFF7);
        peek_bit3("R4", 1'b1);

        // R6: writes to 0, 1 and 3 are ignored
        step(0, 0, 1, 1, 4'd1, 32'hFFFF_FFFF);
        step(0, 0, 1, 1, 4'd3, 32'hFFFF_FFFF);
        step(0, 0, 1, 1, 4'd0, 32'hFFFF_FFFF);
        peek_bit3("R6", 1'b1);
        step(0, 0, 1, 0, 4'd3, 0);

        // R9: unmapped write ignored
        step(0, 0, 1, 1, 4'd9, 32'hFFFF_FFFF);
        peek_bit3("R9", 1'b1);

        // R7: clear meets a still-high insert
        step(0, 1, 1, 1, 4'd2, 32'h8);
        peek_bit3("R7", 1'b1);

        // R4: write-one clears
        step(0, 0, 1, 1, 4'd2, 32'h8);
        peek_bit3("R4", 1'b0);
        step(1, 0, 1, 0, 4'd2, 0);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            bit wp = 1'($urandom);
            bit ci = ($urandom % 16) == 0;
            bit we = 1'($urandom);
            logic [3:0] idx = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 4);
            logic [31:0] wd = $urandom;
            step(wp, ci, 1'b1, we, idx, wd);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule